// File: doc/BRIEF.md
# Periodic Watchdog Service Tick

This block produces one service event at a fixed interval and makes that single event do three jobs together. It feeds the on-chip watchdog its two-value unlock sequence. It inverts a heartbeat pin for an external supervisor. It advances a 16-bit elapsed-time count that a host can read. The interval comes from a 16-bit up-timer. The timer runs on a prescaled timebase, one tick every `PRESCALE` clocks, and starts from `RELOAD`. With the defaults (divide by 12, start at 0xC567) it wraps after 15001 ticks. At each wrap the timer is halted, preloaded again and restarted.

The watchdog counts ticks from its own free-running prescaler, so dropping `enable` does not stop it. If no valid unlock sequence arrives within `WDT_LIMIT` ticks, the watchdog raises a one-cycle reset request and starts counting again from zero.

A service sequencer steps through named states: RUN, HALT, LOAD, KEY_A, KEY_B, BUMP.
- RUN counts ticks. RUN moves to HALT on the tick that finds the timer at all-ones.
- HALT holds the stopped timer.
- LOAD preloads `RELOAD`.
- KEY_A writes the first key to the watchdog, and KEY_B writes the second key.
- BUMP inverts the heartbeat, increments the count, and returns to RUN.

The watchdog unlock logic has two states, LOCKED and ARMED:
- A write of the first key moves it to ARMED.
- In ARMED, a write of the second key clears the watchdog and returns to LOCKED.
- In ARMED, any other value returns it to LOCKED without clearing.
- In ARMED, a repeat of the first key keeps it ARMED.

Top module: `wdt_service_tick`

## Requirements
- R1: After reset, `heartbeat` is 0, `tick_count` is 0 and `sys_rst_req` is 0.
- R2: With `enable` held high, service events occur every (65536 - `RELOAD`) x `PRESCALE` clock cycles. The HALT..BUMP walk takes five cycles and must fit between two ticks, so `PRESCALE` must be at least 6.
- R3: While `enable` is low, the service timebase holds and no event occurs. `tick_count` and `heartbeat` keep their values. Counting resumes where it stopped, so the count equals the number of whole periods of enabled cycles.
- R4: Each event increments `tick_count` by exactly one. The low byte steps first, and the high byte steps only when the low byte wraps. Both bytes change on the same clock edge, so 0x00FF is followed directly by 0x0100.
- R5: `heartbeat` inverts on exactly the edges on which `tick_count` changes, so `heartbeat` always equals bit 0 of the count.
- R6: The watchdog is cleared only when a write of `UNLOCK_FIRST` (0x1E) is followed by a next write of `UNLOCK_SECOND` (0xE1). Each service event issues these two writes in KEY_A and KEY_B.
- R7: If the write after 0x1E carries any other value, the sequence is abandoned and the watchdog is not cleared. The bench shows this with an instance whose second service key is 0x5A: its reset requests continue every timeout although its heartbeat runs.
- R8: If the watchdog is not cleared for `WDT_LIMIT` free-running ticks, `sys_rst_req` is high for exactly one cycle and the watchdog count restarts. Uncleared requests therefore repeat every `WDT_LIMIT` x `PRESCALE` cycles.
- R9: While events occur at the configured period, which is shorter than the timeout, `sys_rst_req` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the service timebase; the watchdog timebase is not affected |
| heartbeat | output | 1 | Inverted on every service event |
| tick_count | output | COUNT_W | Number of service events since reset |
| sys_rst_req | output | 1 | One-cycle reset request on watchdog timeout |

## Verification
The bench exercises the service path with several on/off patterns of `enable` of different lengths and positions. The expected count after each pattern is the number of whole periods of enabled cycles, which tells a timebase that truly holds apart from one that drifts or loses ticks. Held-enable runs measure the exact period and the heartbeat/count pairing, and a long run crosses 0x00FF to 0x0100 to expose byte-carry faults. Stopping service isolates the timeout interval and the single-cycle pulse width. A second instance that sends a wrong second key separates "heartbeat runs" from "watchdog is cleared".

// File: rtl/wdt_tick_pkg.sv
package wdt_tick_pkg;

    typedef enum logic [2:0] {
        SVC_RUN,
        SVC_HALT,
        SVC_LOAD,
        SVC_KEY_A,
        SVC_KEY_B,
        SVC_BUMP
    } svc_state_e;

    typedef enum logic {
        WD_LOCKED,
        WD_ARMED
    } wd_state_e;

endpackage

// File: rtl/wdt_tick_prescale.sv
module wdt_tick_prescale #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    generate
        if (DIV < 2) begin : g_pass
            assign tick = en;
        end else begin : g_div
            localparam int W = $clog2(DIV);
            localparam logic [W-1:0] LAST = W'(DIV - 1);
            logic [W-1:0] cnt_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (en) begin
                    if (cnt_q == LAST) begin
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            end

            assign tick = en && (cnt_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/wdt_tick_sequencer.sv
module wdt_tick_sequencer
    import wdt_tick_pkg::*;
#(
    parameter int              TIMER_W = 16,
    parameter logic [TIMER_W-1:0] RELOAD = 16'hC567,
    parameter int              KEY_W   = 8,
    parameter logic [KEY_W-1:0] KEY_A  = 8'h1E,
    parameter logic [KEY_W-1:0] KEY_B  = 8'hE1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    output logic             wr_en,
    output logic [KEY_W-1:0] wr_data,
    output logic             bump
);
    localparam logic [TIMER_W-1:0] TOP = '1;

    svc_state_e         state_q, state_d;
    logic [TIMER_W-1:0] tmr_q, tmr_d;
    logic               wrap;

    assign wrap = tick && (tmr_q == TOP);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SVC_RUN;
            tmr_q   <= RELOAD;
        end else begin
            state_q <= state_d;
            tmr_q   <= tmr_d;
        end
    end

    // next state and timer datapath
    always_comb begin
        state_d = state_q;
        tmr_d   = tmr_q;
        unique case (state_q)
            SVC_RUN: begin
                if (wrap) begin
                    tmr_d   = '0;
                    state_d = SVC_HALT;
                end else if (tick) begin
                    tmr_d = tmr_q + 1'b1;
                end
            end
            SVC_HALT:  state_d = SVC_LOAD;
            SVC_LOAD: begin
                tmr_d   = RELOAD;
                state_d = SVC_KEY_A;
            end
            SVC_KEY_A: state_d = SVC_KEY_B;
            SVC_KEY_B: state_d = SVC_BUMP;
            SVC_BUMP:  state_d = SVC_RUN;
            default:   state_d = SVC_RUN;
        endcase
    end

    // outputs
    always_comb begin
        wr_en   = 1'b0;
        wr_data = '0;
        bump    = 1'b0;
        unique case (state_q)
            SVC_KEY_A: begin
                wr_en   = 1'b1;
                wr_data = KEY_A;
            end
            SVC_KEY_B: begin
                wr_en   = 1'b1;
                wr_data = KEY_B;
            end
            SVC_BUMP: bump = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/wdt_tick_watchdog.sv
module wdt_tick_watchdog
    import wdt_tick_pkg::*;
#(
    parameter int               LIMIT = 16367,
    parameter int               KEY_W = 8,
    parameter logic [KEY_W-1:0] KEY_A = 8'h1E,
    parameter logic [KEY_W-1:0] KEY_B = 8'hE1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr_en,
    input  logic [KEY_W-1:0] wr_data,
    output logic             clear,
    output logic             rst_req
);
    localparam int          CW   = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    wd_state_e       state_q, state_d;
    logic [CW-1:0]   cnt_q;
    logic            rst_q;
    logic            expire;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WD_LOCKED;
        end else begin
            state_q <= state_d;
        end
    end

    // unlock sequence
    always_comb begin
        state_d = state_q;
        clear   = 1'b0;
        unique case (state_q)
            WD_LOCKED: begin
                if (wr_en && wr_data == KEY_A) begin
                    state_d = WD_ARMED;
                end
            end
            WD_ARMED: begin
                if (wr_en) begin
                    if (wr_data == KEY_B) begin
                        clear   = 1'b1;
                        state_d = WD_LOCKED;
                    end else if (wr_data == KEY_A) begin
                        state_d = WD_ARMED;
                    end else begin
                        state_d = WD_LOCKED;
                    end
                end
            end
            default: state_d = WD_LOCKED;
        endcase
    end

    assign expire = tick && (cnt_q == LAST) && !clear;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            rst_q <= 1'b0;
        end else begin
            rst_q <= expire;
            if (clear || expire) begin
                cnt_q <= '0;
            end else if (tick) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign rst_req = rst_q;
endmodule

// File: rtl/wdt_tick_counter.sv
module wdt_tick_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bump,
    output logic         heartbeat,
    output logic [W-1:0] count
);
    localparam int NB = W / 8;

    logic [NB:0]  carry;
    logic [W-1:0] cnt_q;
    logic         hb_q;

    assign carry[0] = bump;

    generate
        for (genvar b = 0; b < NB; b++) begin : g_byte
            assign carry[b+1] = carry[b] && (cnt_q[b*8 +: 8] == 8'hFF);

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q[b*8 +: 8] <= 8'h00;
                end else if (carry[b]) begin
                    cnt_q[b*8 +: 8] <= cnt_q[b*8 +: 8] + 8'h01;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hb_q <= 1'b0;
        end else if (bump) begin
            hb_q <= ~hb_q;
        end
    end

    assign heartbeat = hb_q;
    assign count     = cnt_q;
endmodule

// File: rtl/wdt_service_tick.sv
module wdt_service_tick #(
    parameter int               PRESCALE      = 12,
    parameter int               TIMER_W       = 16,
    parameter logic [15:0]      RELOAD        = 16'hC567,
    parameter int               WDT_LIMIT     = 16367,
    parameter int               COUNT_W       = 16,
    parameter int               KEY_W         = 8,
    parameter logic [7:0]       UNLOCK_FIRST  = 8'h1E,
    parameter logic [7:0]       UNLOCK_SECOND = 8'hE1,
    parameter logic [7:0]       SVC_FIRST     = UNLOCK_FIRST,
    parameter logic [7:0]       SVC_SECOND    = UNLOCK_SECOND
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    output logic               heartbeat,
    output logic [COUNT_W-1:0] tick_count,
    output logic               sys_rst_req
);
    logic             svc_tick;
    logic             wd_tick;
    logic             svc_wr_en;
    logic [KEY_W-1:0] svc_wr_data;
    logic             svc_bump;
    logic             wd_clear;

    wdt_tick_prescale #(.DIV(PRESCALE)) u_svc_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (enable),
        .tick (svc_tick)
    );

    wdt_tick_prescale #(.DIV(PRESCALE)) u_wd_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (1'b1),
        .tick (wd_tick)
    );

    wdt_tick_sequencer #(
        .TIMER_W(TIMER_W),
        .RELOAD (TIMER_W'(RELOAD)),
        .KEY_W  (KEY_W),
        .KEY_A  (KEY_W'(SVC_FIRST)),
        .KEY_B  (KEY_W'(SVC_SECOND))
    ) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (svc_tick),
        .wr_en  (svc_wr_en),
        .wr_data(svc_wr_data),
        .bump   (svc_bump)
    );

    wdt_tick_watchdog #(
        .LIMIT(WDT_LIMIT),
        .KEY_W(KEY_W),
        .KEY_A(KEY_W'(UNLOCK_FIRST)),
        .KEY_B(KEY_W'(UNLOCK_SECOND))
    ) u_wd (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (wd_tick),
        .wr_en  (svc_wr_en),
        .wr_data(svc_wr_data),
        .clear  (wd_clear),
        .rst_req(sys_rst_req)
    );

    wdt_tick_counter #(.W(COUNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .bump     (svc_bump),
        .heartbeat(heartbeat),
        .count    (tick_count)
    );
endmodule

// File: rtl/wdt_service_tick_chk.sv
module wdt_service_tick_chk #(
    parameter int         COUNT_W = 16,
    parameter int         KEY_W   = 8,
    parameter logic [7:0] FIRST   = 8'h1E
) (
    input logic               clk,
    input logic               rst_n,
    input logic               heartbeat,
    input logic [COUNT_W-1:0] tick_count,
    input logic               sys_rst_req,
    input logic               svc_wr_en,
    input logic [KEY_W-1:0]   svc_wr_data,
    input logic               wd_clear
);
    p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_count != $past(tick_count)) |-> (tick_count == $past(tick_count) + 1'b1));

    p_hb_follows_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_count != $past(tick_count)) |-> (heartbeat != $past(heartbeat)));

    p_clear_after_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wd_clear |-> ($past(svc_wr_en) && $past(svc_wr_data) == KEY_W'(FIRST)));

    p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req |=> !sys_rst_req);

    p_no_rst_after_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wd_clear |=> !sys_rst_req);
endmodule

bind wdt_service_tick wdt_service_tick_chk #(
    .COUNT_W(COUNT_W),
    .KEY_W  (KEY_W),
    .FIRST  (UNLOCK_FIRST)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .heartbeat  (heartbeat),
    .tick_count (tick_count),
    .sys_rst_req(sys_rst_req),
    .svc_wr_en  (svc_wr_en),
    .svc_wr_data(svc_wr_data),
    .wd_clear   (wd_clear)
);

// File: tb/wdt_service_tick_bench.sv
module wdt_service_tick_bench;
    localparam int          P      = 8;
    localparam logic [15:0] RLD    = 16'hFFF0;
    localparam int          LIM    = 20;
    localparam int          PERIOD = (65536 - 16'hFFF0) * P;   // 128
    localparam int          TMO    = LIM * P;                  // 160

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        hb, b_hb, rq, b_rq;
    logic [15:0] cnt, b_cnt;
    int          cyc = 0;
    int          checks = 0;
    int          failures = 0;
    int          g_pulses = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wdt_service_tick #(.PRESCALE(P), .RELOAD(RLD), .WDT_LIMIT(LIM)) u_wdt_service_tick (
        .clk(clk), .rst_n(rst_n), .enable(en),
        .heartbeat(hb), .tick_count(cnt), .sys_rst_req(rq)
    );

    wdt_service_tick #(.PRESCALE(P), .RELOAD(RLD), .WDT_LIMIT(LIM), .SVC_SECOND(8'h5A)) u_bad_key (
        .clk(clk), .rst_n(rst_n), .enable(1'b1),
        .heartbeat(b_hb), .tick_count(b_cnt), .sys_rst_req(b_rq)
    );

    always @(negedge clk) if (rst_n && rq) g_pulses <= g_pulses + 1;

    // rows: {enable, cycles, expected count}
    localparam logic [32:0] VEC [6] = '{
        {1'b1, 16'd100, 16'd0},
        {1'b0, 16'd10,  16'd0},
        {1'b1, 16'd60,  16'd1},
        {1'b1, 16'd200, 16'd2},
        {1'b0, 16'd10,  16'd2},
        {1'b1, 16'd40,  16'd3}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_high(input bit bad, input int limit, output int at);
        at = -1;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if ((bad ? b_rq : rq) === 1'b1) begin
                at = cyc;
                return;
            end
        end
    endtask

    task automatic wait_hb(input int limit, output int at);
        logic prev;
        prev = hb;
        at = -1;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (hb !== prev) begin
                at = cyc;
                return;
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog timeout of bench");
        $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
        $finish;
    end

    initial begin
        int t1, t2, t3, pulses0;
        logic [15:0] c0;
        logic h0;
        step(3);
        // R1 reset state
        check("R1 heartbeat", hb, 0);
        check("R1 count", cnt, 0);
        check("R1 rst_req", rq, 0);

        @(negedge clk);
        rst_n = 1'b1;
        // R3 enable patterns walked from the table
        for (int i = 0; i < 6; i++) begin
            en = VEC[i][32];
            step(int'(VEC[i][31:16]));
            check("R3 count after pattern", cnt, VEC[i][15:0]);
            check("R5 heartbeat parity", hb, VEC[i][0]);
        end
        check("R9 no reset while serviced", g_pulses, 0);

        // R2 exact period and R5 pairing
        en = 1'b1;
        wait_hb(400, t1);
        c0 = cnt;
        wait_hb(400, t2);
        check("R2 period", t2 - t1, PERIOD);
        check("R4 step of one", cnt, c0 + 16'd1);
        check("R5 heartbeat equals count bit0", hb, cnt[0]);

        // R8 timeout when service stops; R3 count holds
        en = 1'b0;
        c0 = cnt;
        h0 = hb;
        wait_high(0, 400, t1);
        step(1);
        check("R8 pulse width one", rq, 0);
        wait_high(0, 400, t2);
        check("R8 repeat interval", t2 - t1, TMO);
        check("R3 count held while disabled", cnt, c0);
        check("R3 heartbeat held while disabled", hb, h0);

        // R9 resumed service keeps reset quiet; R7 bad key keeps firing
        en = 1'b1;
        wait_hb(400, t3);
        pulses0 = g_pulses;
        wait_high(1, 400, t1);
        step(1);
        wait_high(1, 400, t2);
        check("R7 wrong key timeout interval", t2 - t1, TMO);
        check("R7 wrong key heartbeat running", b_cnt != 0, 1);
        step(300);
        check("R9 no reset after resume", g_pulses, pulses0);
        check("R6 correct keys clear watchdog", (b_cnt != 0) && (g_pulses == pulses0), 1);

        // R4 byte carry 0x00FF -> 0x0100
        for (int i = 0; i < 40000 && cnt != 16'h00FF; i++) @(negedge clk);
        check("R4 reached 0x00FF", cnt, 16'h00FF);
        wait_hb(400, t1);
        check("R4 carry into high byte", cnt, 16'h0100);
        check("R5 heartbeat after carry", hb, 0);

        // R1 reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        step(2);
        check("R1 count after reset", cnt, 0);
        check("R1 heartbeat after reset", hb, 0);
        check("R1 rst_req after reset", rq, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule